// File: doc/BRIEF.md
# Low-Power Mode and Wakeup Controller

This block sequences the power state of a small microcontroller core. The operating mode lives in four bits of the CPU status word: CPU-off, oscillator-off, and two clock-generator disables. The controller holds that word, decodes the bits into clock enables for the CPU, the fast system clock, the clock-generator loop and the slow auxiliary clock, and reports a mode code. Software changes the mode by writing the status word. The new enables take effect on the cycle after the write.

On interrupt entry the controller hands out the full status word for stacking. It then clears the mode bits and the global interrupt enable, so the handler runs in active mode. On return it reloads the word that comes back from the stack. If the handler edited the stacked copy, the core resumes the edited mode. In the shallow low-power modes, any interrupt that is both individually enabled and globally enabled wakes the core and turns all clocks back on.

A separate select bit turns the two deepest shallow patterns into shutdown variants. In shutdown the regulator enable drops and a latched pad-freeze output rises. Only power-up, a reset event or a pad wake input can exit; the lighter shutdown variant also accepts a real-time-clock event. Exit runs a restart: the regulator comes back on, a fixed settle count elapses, a one-cycle reset pulse is issued and the status word is cleared. The pad freeze holds until software clears it. While a debug probe is attached, shutdown requests fall back to the shallow mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Status word bit positions are gie=0, cpu_off=1, osc_off=2, scg0=3, scg1=4. When the core is running and no wake is present, cpu_clk_en_o=!cpu_off, aux_clk_en_o=!osc_off, dco_en_o=!scg0 and fast_clk_en_o=!scg1. These outputs change on the cycle after the clock edge that accepts the write.
- R2: mode_o reports 0 when cpu_off is clear. With cpu_off set it reports 1 when no scg bit is set, 2 for scg0 only, 3 for scg1 only, 4 for scg0 and scg1, and 5 for scg0, scg1 and osc_off. The other codes are 6 for the light shutdown, 7 for the deep shutdown and 8 during restart.
- R3: An irq_entry_i pulse gives a one-cycle save_vld_o on the next cycle. save_word_o then carries the status word as it was before entry, and sr_o has gie, cpu_off, osc_off, scg0 and scg1 cleared.
- R4: A reti_i pulse loads restore_word_i into sr_o. An unchanged saved word resumes the earlier mode. An edited word resumes the edited mode.
- R5: While running, wake_o is high whenever cpu_off and gie are set and (irq_req_i & irq_en_i) is non-zero. The same cycle it forces all four clock enables high.
- R6: A write that sets cpu_off, scg0 and scg1 with deep_sel_i high and dbg_en_i low enters shutdown. osc_off set selects code 7 and osc_off clear selects code 6. From the next cycle reg_en_o is 0, io_lock_o is 1 and all clock enables are 0.
- R7: In code 7, only por_i, rst_evt_i or io_wake_i start a restart. rtc_evt_i, interrupts and status writes leave the block in code 7.
- R8: In code 6, rtc_evt_i also starts a restart.
- R9: The clock edge that accepts a wake source moves the block into restart with reg_en_o high. Exactly SETTLE_CYC cycles later, sys_rst_o is high for one cycle. After that pulse the block runs with sr_o equal to 0.
- R10: io_lock_o stays high through restart and afterwards until a lock_clr_i pulse while running. A lock_clr_i pulse during shutdown has no effect.
- R11: dbg_o follows dbg_en_i. With dbg_en_i high, a shutdown request enters the shallow mode (code 5 or 4) and leaves reg_en_o high and io_lock_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_wr_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | SR_W | Status word write data |
| deep_sel_i | input | 1 | Selects shutdown variant on entry |
| sr_o | output | SR_W | Current status word |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Individual interrupt enables |
| irq_entry_i | input | 1 | Core is vectoring to a handler |
| save_vld_o | output | 1 | Saved word valid for stacking |
| save_word_o | output | SR_W | Status word to stack |
| reti_i | input | 1 | Return from interrupt |
| restore_word_i | input | SR_W | Status word popped from stack |
| wake_o | output | 1 | Shallow-mode wake request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| fast_clk_en_o | output | 1 | Fast system clock enable |
| dco_en_o | output | 1 | Clock-generator loop enable |
| aux_clk_en_o | output | 1 | Slow auxiliary clock enable |
| mode_o | output | 4 | Current mode code |
| por_i | input | 1 | Power-up sequence wake |
| rst_evt_i | input | 1 | Reset event wake |
| io_wake_i | input | 1 | Pad wake source |
| rtc_evt_i | input | 1 | Real-time-clock event |
| reg_en_o | output | 1 | Regulator enable |
| io_lock_o | output | 1 | Pad state freeze |
| sys_rst_o | output | 1 | Restart reset pulse |
| lock_clr_i | input | 1 | Clears pad freeze while running |
| dbg_en_i | input | 1 | Debug probe attached |
| dbg_o | output | 1 | Debug state indicator |

## Verification
The bench targets the RTC event in the deep shutdown. A block that treated both shutdown variants alike would restart there, and a block that ignored the RTC event everywhere would stay stuck in the light variant. It checks a handler that edits the stacked word to active: a controller that restored its own copy would fall back asleep. It counts settle cycles and pulse width exactly, so an off-by-one counter is caught. It also checks that the pad freeze survives the restart and ignores clear pulses issued during shutdown. Random writes with random interrupt masks make sure the wake forcing applies only when both the global and an individual enable are set.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int GIE_B    = 0;
  localparam int CPUOFF_B = 1;
  localparam int OSCOFF_B = 2;
  localparam int SCG0_B   = 3;
  localparam int SCG1_B   = 4;

  typedef enum logic [1:0] {ST_RUN, ST_DEEP, ST_SETTLE, ST_RST} seq_st_e;

  typedef enum logic [3:0] {
    M_ACT = 4'd0, M_LP0 = 4'd1, M_LP1 = 4'd2, M_LP2 = 4'd3, M_LP3 = 4'd4,
    M_LP4 = 4'd5, M_SD3 = 4'd6, M_SD4 = 4'd7, M_RSTRT = 4'd8
  } pm_mode_e;

  typedef struct packed {
    logic scg1;
    logic scg0;
    logic osc_off;
    logic cpu_off;
  } mode_bits_t;

  function automatic pm_mode_e decode_shallow(input mode_bits_t b);
    pm_mode_e m;
    if (!b.cpu_off)              m = M_ACT;
    else if (b.scg0 && b.scg1)   m = b.osc_off ? M_LP4 : M_LP3;
    else if (b.scg1)             m = M_LP2;
    else if (b.scg0)             m = M_LP1;
    else                         m = M_LP0;
    return m;
  endfunction
endpackage

// File: rtl/pm_status_reg.sv
module pm_status_reg
  import pwr_mode_pkg::*;
#(
  parameter int SR_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            freeze_i,
  input  logic            wr_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic            entry_i,
  input  logic            reti_i,
  input  logic [SR_W-1:0] restore_i,
  output logic [SR_W-1:0] sr_o,
  output logic            save_vld_o,
  output logic [SR_W-1:0] save_word_o
);
  localparam logic [SR_W-1:0] ENTRY_CLR =
    (SR_W'(1) << GIE_B)  | (SR_W'(1) << CPUOFF_B) | (SR_W'(1) << OSCOFF_B) |
    (SR_W'(1) << SCG0_B) | (SR_W'(1) << SCG1_B);

  logic [SR_W-1:0] sr_q, save_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      save_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        sr_q   <= '0;
        save_q <= '0;
      end else if (!freeze_i) begin
        if (entry_i) begin
          save_q <= sr_q;
          vld_q  <= 1'b1;
          sr_q   <= sr_q & ~ENTRY_CLR;
        end else if (reti_i) begin
          sr_q <= restore_i;
        end else if (wr_i) begin
          sr_q <= wdata_i;
        end
      end
    end
  end

  assign sr_o        = sr_q;
  assign save_vld_o  = vld_q;
  assign save_word_o = save_q;
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  mode_bits_t       bits_i,
  input  logic             gie_i,
  input  seq_st_e          st_i,
  input  logic             is45_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             wake_o,
  output logic             cpu_clk_en_o,
  output logic             fast_clk_en_o,
  output logic             dco_en_o,
  output logic             aux_clk_en_o,
  output logic [3:0]       mode_o
);
  logic running;
  assign running = (st_i == ST_RUN);
  assign wake_o  = running && bits_i.cpu_off && gie_i && (|(irq_req_i & irq_en_i));

  always_comb begin
    if (!running) begin
      {cpu_clk_en_o, fast_clk_en_o, dco_en_o, aux_clk_en_o} = 4'b0000;
    end else if (wake_o) begin
      {cpu_clk_en_o, fast_clk_en_o, dco_en_o, aux_clk_en_o} = 4'b1111;
    end else begin
      cpu_clk_en_o  = !bits_i.cpu_off;
      fast_clk_en_o = !bits_i.scg1;
      dco_en_o      = !bits_i.scg0;
      aux_clk_en_o  = !bits_i.osc_off;
    end
  end

  always_comb begin
    unique case (st_i)
      ST_RUN:  mode_o = decode_shallow(bits_i);
      ST_DEEP: mode_o = is45_i ? M_SD4 : M_SD3;
      default: mode_o = M_RSTRT;
    endcase
  end
endmodule

// File: rtl/pm_deep_seq.sv
module pm_deep_seq
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    enter_i,
  input  logic    enter45_i,
  input  logic    por_i,
  input  logic    rst_evt_i,
  input  logic    io_wake_i,
  input  logic    rtc_evt_i,
  input  logic    lock_clr_i,
  output seq_st_e st_o,
  output logic    is45_o,
  output logic    reg_en_o,
  output logic    io_lock_o,
  output logic    sys_rst_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is45_q, lock_q, wake_ok;

  // rtc only exits the lighter shutdown
  assign wake_ok = por_i || rst_evt_i || io_wake_i || (rtc_evt_i && !is45_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      is45_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (enter_i) begin
            st_q   <= ST_DEEP;
            is45_q <= enter45_i;
            lock_q <= 1'b1;
          end else if (lock_clr_i) begin
            lock_q <= 1'b0;
          end
        end
        ST_DEEP: begin
          if (wake_ok) begin
            st_q  <= ST_SETTLE;
            cnt_q <= '0;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == CNT_LAST) st_q <= ST_RST;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign st_o      = st_q;
  assign is45_o    = is45_q;
  assign reg_en_o  = (st_q != ST_DEEP);
  assign io_lock_o = lock_q;
  assign sys_rst_o = (st_q == ST_RST);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SR_W       = 8,
  parameter int N_IRQ      = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sr_wr_i,
  input  logic [SR_W-1:0]  sr_wdata_i,
  input  logic             deep_sel_i,
  output logic [SR_W-1:0]  sr_o,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             irq_entry_i,
  output logic             save_vld_o,
  output logic [SR_W-1:0]  save_word_o,
  input  logic             reti_i,
  input  logic [SR_W-1:0]  restore_word_i,
  output logic             wake_o,
  output logic             cpu_clk_en_o,
  output logic             fast_clk_en_o,
  output logic             dco_en_o,
  output logic             aux_clk_en_o,
  output logic [3:0]       mode_o,
  input  logic             por_i,
  input  logic             rst_evt_i,
  input  logic             io_wake_i,
  input  logic             rtc_evt_i,
  output logic             reg_en_o,
  output logic             io_lock_o,
  output logic             sys_rst_o,
  input  logic             lock_clr_i,
  input  logic             dbg_en_i,
  output logic             dbg_o
);
  seq_st_e    st;
  logic       is45, running, enter_deep;
  mode_bits_t cur_bits;

  assign running  = (st == ST_RUN);
  assign cur_bits = '{scg1: sr_o[SCG1_B], scg0: sr_o[SCG0_B],
                      osc_off: sr_o[OSCOFF_B], cpu_off: sr_o[CPUOFF_B]};

  // shutdown request: plain write of the two deepest patterns, no probe attached
  assign enter_deep = running && sr_wr_i && !irq_entry_i && !reti_i && deep_sel_i &&
                      !dbg_en_i && sr_wdata_i[CPUOFF_B] && sr_wdata_i[SCG0_B] &&
                      sr_wdata_i[SCG1_B];

  pm_status_reg #(.SR_W(SR_W)) i_sr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sys_rst_o),
    .freeze_i    (!running),
    .wr_i        (sr_wr_i),
    .wdata_i     (sr_wdata_i),
    .entry_i     (irq_entry_i),
    .reti_i      (reti_i),
    .restore_i   (restore_word_i),
    .sr_o        (sr_o),
    .save_vld_o  (save_vld_o),
    .save_word_o (save_word_o)
  );

  pm_deep_seq #(.SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (enter_deep),
    .enter45_i  (sr_wdata_i[OSCOFF_B]),
    .por_i      (por_i),
    .rst_evt_i  (rst_evt_i),
    .io_wake_i  (io_wake_i),
    .rtc_evt_i  (rtc_evt_i),
    .lock_clr_i (lock_clr_i),
    .st_o       (st),
    .is45_o     (is45),
    .reg_en_o   (reg_en_o),
    .io_lock_o  (io_lock_o),
    .sys_rst_o  (sys_rst_o)
  );

  pm_clk_gate #(.N_IRQ(N_IRQ)) i_gate (
    .bits_i        (cur_bits),
    .gie_i         (sr_o[GIE_B]),
    .st_i          (st),
    .is45_i        (is45),
    .irq_req_i     (irq_req_i),
    .irq_en_i      (irq_en_i),
    .wake_o        (wake_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .fast_clk_en_o (fast_clk_en_o),
    .dco_en_o      (dco_en_o),
    .aux_clk_en_o  (aux_clk_en_o),
    .mode_o        (mode_o)
  );

  assign dbg_o = dbg_en_i;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int SR_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sr_wr_i,
  input logic            irq_entry_i,
  input logic            reti_i,
  input logic [SR_W-1:0] sr_o,
  input logic            save_vld_o,
  input logic            wake_o,
  input logic            cpu_clk_en_o,
  input logic            fast_clk_en_o,
  input logic            dco_en_o,
  input logic            aux_clk_en_o,
  input logic [3:0]      mode_o,
  input logic            por_i,
  input logic            rst_evt_i,
  input logic            io_wake_i,
  input logic            rtc_evt_i,
  input logic            reg_en_o,
  input logic            io_lock_o,
  input logic            sys_rst_o,
  input logic            lock_clr_i,
  input logic            dbg_en_i
);
  p_entry_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_entry_i && mode_o < 4'd6) |=> (save_vld_o && !sr_o[CPUOFF_B] && !sr_o[GIE_B]));

  p_wake_clocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cpu_clk_en_o && fast_clk_en_o && dco_en_o && aux_clk_en_o));

  p_shutdown_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd6 || mode_o == 4'd7) |-> (!reg_en_o && io_lock_o && !cpu_clk_en_o));

  p_rtc_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd7 && !por_i && !rst_evt_i && !io_wake_i) |=> mode_o == 4'd7);

  p_rst_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (!sys_rst_o && sr_o == '0));

  p_lock_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_lock_o) |-> ($past(lock_clr_i) && $past(mode_o) < 4'd6));

  p_dbg_reg_on_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en_i && sr_wr_i && !irq_entry_i && !reti_i && mode_o < 4'd6) |=> reg_en_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.SR_W(SR_W)) i_chk (.*);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int SR_W = 8, N_IRQ = 8, SETTLE = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sr_wr_i = 0, deep_sel_i = 0, irq_entry_i = 0, reti_i = 0;
  logic [SR_W-1:0] sr_wdata_i = '0, restore_word_i = '0;
  logic [N_IRQ-1:0] irq_req_i = '0, irq_en_i = '0;
  logic por_i = 0, rst_evt_i = 0, io_wake_i = 0, rtc_evt_i = 0, lock_clr_i = 0, dbg_en_i = 0;
  logic [SR_W-1:0] sr_o, save_word_o;
  logic save_vld_o, wake_o, cpu_clk_en_o, fast_clk_en_o, dco_en_o, aux_clk_en_o;
  logic reg_en_o, io_lock_o, sys_rst_o, dbg_o;
  logic [3:0] mode_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pwr_mode_ctrl #(.SR_W(SR_W), .N_IRQ(N_IRQ), .SETTLE_CYC(SETTLE)) i_pwr_mode_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mode(input logic [SR_W-1:0] w);
    if (!w[1])           return 4'd0;
    if (w[3] && w[4])    return w[2] ? 4'd5 : 4'd4;
    if (w[4])            return 4'd3;
    if (w[3])            return 4'd2;
    return 4'd1;
  endfunction

  // {cpu, fast, dco, aux}
  function automatic logic [3:0] exp_clk(input logic [SR_W-1:0] w, input logic wk);
    if (wk) return 4'b1111;
    return {!w[1], !w[4], !w[3], !w[2]};
  endfunction

  function automatic logic [3:0] clks();
    return {cpu_clk_en_o, fast_clk_en_o, dco_en_o, aux_clk_en_o};
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic write_sr(input logic [SR_W-1:0] w, input logic deep);
    sr_wdata_i = w; deep_sel_i = deep; sr_wr_i = 1;
    tick();
    sr_wr_i = 0; deep_sel_i = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  task automatic restart_check(input string req);
    int n = 0;
    check({req, " restart mode"}, mode_o, 4'd8);
    check({req, " regulator back on"}, reg_en_o, 1);
    while (!sys_rst_o && n < 100) begin tick(); n++; end
    check("R9 settle cycles", n, SETTLE);
    tick();
    check("R9 pulse one cycle", sys_rst_o, 0);
    check("R9 status cleared", sr_o, 0);
    check("R9 running active", mode_o, 4'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SR_W-1:0] w;
    logic wk;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    tick();
    // reset state
    check("R1 reset clocks", clks(), 4'b1111);
    check("R2 reset mode", mode_o, 0);
    check("R6 reset regulator", reg_en_o, 1);
    check("R10 reset lock", io_lock_o, 0);
    check("R9 reset pulse", sys_rst_o, 0);

    // directed: each shallow mode
    write_sr(8'h02, 0); check("R1 lpm0 clocks", clks(), 4'b0111); check("R2 lpm0", mode_o, 1);
    write_sr(8'h0A, 0); check("R1 lpm1 clocks", clks(), 4'b0101); check("R2 lpm1", mode_o, 2);
    write_sr(8'h12, 0); check("R1 lpm2 clocks", clks(), 4'b0011); check("R2 lpm2", mode_o, 3);
    write_sr(8'h1A, 0); check("R1 lpm3 clocks", clks(), 4'b0001); check("R2 lpm3", mode_o, 4);
    write_sr(8'h1E, 0); check("R1 lpm4 clocks", clks(), 4'b0000); check("R2 lpm4", mode_o, 5);
    write_sr(8'h00, 0); check("R1 active clocks", clks(), 4'b1111);

    // random writes with random interrupt masks
    for (int i = 0; i < 300; i++) begin
      w = 8'($urandom);
      irq_req_i = 8'($urandom & $urandom);
      irq_en_i  = 8'($urandom);
      write_sr(w, 0);
      wk = w[1] && w[0] && (|(irq_req_i & irq_en_i));
      check("R5 wake", wake_o, wk);
      check("R1 clocks random", clks(), exp_clk(w, wk));
      check("R2 mode random", mode_o, exp_mode(w));
    end
    irq_req_i = '0; irq_en_i = '0;

    // entry / return, stacked word unchanged then edited
    write_sr(8'h1B, 0);
    irq_req_i = 8'h10; irq_en_i = 8'h10; #1;
    check("R5 wake directed", wake_o, 1);
    check("R5 wake clocks", clks(), 4'b1111);
    pulse(irq_entry_i);
    irq_req_i = '0;
    check("R3 save valid", save_vld_o, 1);
    check("R3 saved word", save_word_o, 8'h1B);
    check("R3 handler active", sr_o & 8'h1F, 0);
    tick();
    check("R3 save pulse one cycle", save_vld_o, 0);
    restore_word_i = 8'h1B; pulse(reti_i);
    check("R4 resume unchanged", mode_o, 4);
    irq_req_i = 8'h10; #1; pulse(irq_entry_i); irq_req_i = '0;
    restore_word_i = 8'h01; pulse(reti_i);
    check("R4 resume edited", mode_o, 0);
    check("R4 edited clocks", clks(), 4'b1111);

    // deep shutdown: rtc rejected
    write_sr(8'h1E, 1);
    check("R6 deep code", mode_o, 7);
    check("R6 regulator off", reg_en_o, 0);
    check("R6 lock on", io_lock_o, 1);
    check("R6 clocks off", clks(), 4'b0000);
    pulse(rtc_evt_i); tick();
    check("R7 rtc ignored", mode_o, 7);
    irq_req_i = '1; irq_en_i = '1; tick(); irq_req_i = '0; irq_en_i = '0;
    check("R7 irq ignored", mode_o, 7);
    write_sr(8'h00, 0);
    check("R7 write ignored", mode_o, 7);
    pulse(lock_clr_i);
    check("R10 clear ignored in shutdown", io_lock_o, 1);
    pulse(io_wake_i);
    restart_check("R7 io wake");
    check("R10 lock held after restart", io_lock_o, 1);
    pulse(lock_clr_i);
    check("R10 lock cleared", io_lock_o, 0);

    // deep shutdown exits via power-up and reset event
    write_sr(8'h1E, 1); pulse(por_i);  restart_check("R7 por wake");
    write_sr(8'h1E, 1); pulse(rst_evt_i); restart_check("R7 reset event wake");
    pulse(lock_clr_i);

    // light shutdown: rtc accepted
    write_sr(8'h1A, 1);
    check("R6 light code", mode_o, 6);
    check("R6 light regulator", reg_en_o, 0);
    pulse(rtc_evt_i);
    restart_check("R8 rtc wake");
    pulse(lock_clr_i);

    // debug probe attached
    dbg_en_i = 1; #1;
    check("R11 dbg out", dbg_o, 1);
    write_sr(8'h1E, 1);
    check("R11 shallow instead", mode_o, 5);
    check("R11 regulator on", reg_en_o, 1);
    check("R11 no lock", io_lock_o, 0);
    write_sr(8'h1A, 1);
    check("R11 light shallow", mode_o, 4);
    dbg_en_i = 0; write_sr(8'h00, 0);
    check("R11 dbg out low", dbg_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule